// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block handles in-band flow control for one serial channel. Each character that arrives from the receive deserializer is compared against four programmable control characters. A recognised stop character asks the local transmitter to pause. The pause takes effect once the character on the wire has finished. A recognised start character, or any character if the user chooses, lifts the pause. Every received character, control characters included, is still passed on to the receive FIFO.

The block also watches the receive FIFO fill level. When the level reaches an upper mark, it asks the transmitter to send a stop character, or a stop pair, ahead of normal data. When the level later falls to a lower mark, it asks for one start character, or a start pair. These inserted characters bypass the pause, so a start character can still go out while local transmission is halted. A 4-bit mode field chooses the single or paired character sets for matching and for insertion, each on its own. A stop interrupt flag can be raised on each recognised stop character.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, `tx_suspend`, `ins_req` and `xoff_irq` are 0.
- R2: In a single receive mode (`mode[1:0]` = 1 uses `off_a`/`on_a`, = 2 uses `off_b`/`on_b`), a received character equal to the selected stop character makes `tx_suspend` 1 two cycles after the strobe, provided `tx_busy` is low.
- R3: `tx_suspend` only rises in the cycle after one in which `tx_busy` was low; while `tx_busy` stays high, a pending stop does not assert it.
- R4: A received character equal to the selected start character clears `tx_suspend` two cycles later. With `resume_any` high, any received character that is not itself a stop match also clears it.
- R5: In paired receive mode (`mode[1:0]` = 3), a stop is recognised only when `off_a` is directly followed by `off_b`, and a start only when `on_a` is directly followed by `on_b`. If any other character comes between them, the sequence is dropped and nothing happens.
- R6: A recognised stop sets `xoff_irq` when `irq_en` is high. It does not set it when `irq_en` is low. An `irq_ack` pulse clears it.
- R7: Every received character, including control characters, appears on `fifo_wr`/`fifo_data` in the same cycle as its strobe.
- R8: With insertion enabled, when `rx_level >= hi_mark` and no stop is outstanding, `ins_req` rises one cycle later. It carries `off_a` (`mode[3:2]` = 1), `off_b` (= 2), or `off_a` then `off_b` (= 3). Each character is held until `ins_ack`.
- R9: Once a stop has been inserted, a start character (`on_a`, `on_b`, or `on_a` then `on_b`, using the same mode selection) is inserted when `rx_level <= lo_mark`. Each crossing produces exactly one insertion, and levels between the marks produce none.
- R10: Insertion requests are raised and served while `tx_suspend` is 1.
- R11: `mode[1:0]` = 0 disables matching and clears any pause. `mode[3:2]` = 0 disables insertion and clears a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | CW | Received character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | CW | Character written to the receive FIFO |
| on_a | input | CW | First start character |
| on_b | input | CW | Second start character |
| off_a | input | CW | First stop character |
| off_b | input | CW | Second stop character |
| mode | input | 4 | [1:0] receive match mode, [3:2] insertion mode |
| resume_any | input | 1 | Any received character lifts the pause |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_suspend | output | 1 | Normal transmit data must hold |
| rx_level | input | LW | Receive FIFO fill level |
| hi_mark | input | LW | Level that triggers stop insertion |
| lo_mark | input | LW | Level that triggers start insertion |
| ins_req | output | 1 | Request to send a flow character |
| ins_char | output | CW | Flow character to send |
| ins_ack | input | 1 | Transmitter has taken `ins_char` |
| irq_en | input | 1 | Stop interrupt enable |
| irq_ack | input | 1 | Interrupt identification read; clears the flag |
| xoff_irq | output | 1 | Stop interrupt flag |

## Verification
The hold property on `ins_char` assumes the four control characters and `mode` stay constant while a request is outstanding. The bench changes them only while `ins_req` is low. The stop characters are kept distinct from the start characters and from the random filler characters, which are drawn from 0x40 to 0x5F so they never match by accident. The interrupt properties assume `irq_ack` is a pulse from the host. The random receive phase keeps `tx_busy` low, so the expected pause state follows directly from the character history under each mode.

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
  parameter int CW = 8,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_char,
  output logic          fifo_wr,
  output logic [CW-1:0] fifo_data,
  input  logic [CW-1:0] on_a,
  input  logic [CW-1:0] on_b,
  input  logic [CW-1:0] off_a,
  input  logic [CW-1:0] off_b,
  input  logic [3:0]    mode,
  input  logic          resume_any,
  input  logic          tx_busy,
  output logic          tx_suspend,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] hi_mark,
  input  logic [LW-1:0] lo_mark,
  output logic          ins_req,
  output logic [CW-1:0] ins_char,
  input  logic          ins_ack,
  input  logic          irq_en,
  input  logic          irq_ack,
  output logic          xoff_irq
);

  logic [1:0] rxm, txm;
  assign rxm = mode[1:0];
  assign txm = mode[3:2];

  logic          pend_off, pend_on, halt_q, sent_off, ins_on;
  logic [1:0]    ins_left;
  logic [CW-1:0] m_off, m_on;
  logic          single, paired, hit_off, hit_on, wake, sel2;

  assign fifo_wr   = rx_valid;
  assign fifo_data = rx_char;

  assign single = (rxm == 2'd1) || (rxm == 2'd2);
  assign paired = (rxm == 2'd3);
  assign m_off  = (rxm == 2'd2) ? off_b : off_a;
  assign m_on   = (rxm == 2'd2) ? on_b  : on_a;

  assign hit_off = rx_valid && ((single && rx_char == m_off) ||
                                (paired && pend_off && rx_char == off_b));
  assign hit_on  = rx_valid && ((single && rx_char == m_on) ||
                                (paired && pend_on && rx_char == on_b));
  assign wake    = hit_on || (rx_valid && resume_any && rxm != 2'd0 && !hit_off);

  assign sel2     = (txm == 2'd2) || (txm == 2'd3 && ins_left == 2'd1);
  assign ins_req  = (ins_left != 2'd0);
  assign ins_char = ins_on ? (sel2 ? on_b : on_a) : (sel2 ? off_b : off_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off   <= 1'b0;
      pend_on    <= 1'b0;
      halt_q     <= 1'b0;
      tx_suspend <= 1'b0;
      xoff_irq   <= 1'b0;
    end else begin
      if (!paired) begin
        pend_off <= 1'b0;
        pend_on  <= 1'b0;
      end else if (rx_valid) begin
        pend_off <= (rx_char == off_a);
        pend_on  <= (rx_char == on_a);
      end

      if (rxm == 2'd0)  halt_q <= 1'b0;
      else if (hit_off) halt_q <= 1'b1;
      else if (wake)    halt_q <= 1'b0;

      if (!halt_q)       tx_suspend <= 1'b0;
      else if (!tx_busy) tx_suspend <= 1'b1;

      if (hit_off && irq_en) xoff_irq <= 1'b1;
      else if (irq_ack)      xoff_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_left <= 2'd0;
      ins_on   <= 1'b0;
      sent_off <= 1'b0;
    end else if (txm == 2'd0) begin
      ins_left <= 2'd0;
      sent_off <= 1'b0;
    end else if (ins_left != 2'd0) begin
      if (ins_ack) ins_left <= ins_left - 2'd1;
    end else if (!sent_off && rx_level >= hi_mark) begin
      ins_left <= (txm == 2'd3) ? 2'd2 : 2'd1;
      ins_on   <= 1'b0;
      sent_off <= 1'b1;
    end else if (sent_off && rx_level <= lo_mark) begin
      ins_left <= (txm == 2'd3) ? 2'd2 : 2'd1;
      ins_on   <= 1'b1;
      sent_off <= 1'b0;
    end
  end

endmodule

// File: rtl/swfc_ctrl_chk.sv
module swfc_ctrl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          tx_busy,
  input logic          tx_suspend,
  input logic          ins_req,
  input logic          ins_ack,
  input logic [CW-1:0] ins_char,
  input logic          irq_en,
  input logic          irq_ack,
  input logic          xoff_irq,
  input logic [3:0]    mode
);

  a_r3_stop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_suspend) |-> !$past(tx_busy));

  a_r8_ins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && !ins_ack |=> ins_req && $stable(ins_char));

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_irq) |-> $past(rx_valid && irq_en));

  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xoff_irq) |-> $past(irq_ack));

  a_r11_ins_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode[3:2] == 2'd0 |=> !ins_req);

endmodule

bind swfc_ctrl swfc_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_busy(tx_busy),
  .tx_suspend(tx_suspend), .ins_req(ins_req), .ins_ack(ins_ack),
  .ins_char(ins_char), .irq_en(irq_en), .irq_ack(irq_ack),
  .xoff_irq(xoff_irq), .mode(mode)
);

// File: tb/tb_swfc_ctrl.sv
module tb_swfc_ctrl;
  localparam int CW = 8;
  localparam int LW = 7;
  localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h21, XOFF1 = 8'h13, XOFF2 = 8'h23;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, resume_any = 0, tx_busy = 0, ins_ack = 0, irq_en = 0, irq_ack = 0;
  logic [CW-1:0] rx_char = 0;
  logic [3:0] mode = 0;
  logic [LW-1:0] rx_level = 0, hi_mark = 7'd48, lo_mark = 7'd16;
  logic fifo_wr, tx_suspend, ins_req, xoff_irq;
  logic [CW-1:0] fifo_data, ins_char;

  int vecs = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swfc_ctrl #(.CW(CW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .on_a(XON1), .on_b(XON2), .off_a(XOFF1), .off_b(XOFF2),
    .mode(mode), .resume_any(resume_any), .tx_busy(tx_busy),
    .tx_suspend(tx_suspend), .rx_level(rx_level), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .ins_req(ins_req), .ins_char(ins_char),
    .ins_ack(ins_ack), .irq_en(irq_en), .irq_ack(irq_ack), .xoff_irq(xoff_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends one character; checks R7 forwarding; returns after tx_suspend has settled
  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1; rx_char = c;
    #1;
    chk(fifo_wr == 1'b1 && fifo_data == c, "R7", {fifo_wr, fifo_data}, {1'b1, c});
    @(negedge clk);
    rx_valid = 0;
    cyc(2);
  endtask

  task automatic take(input logic [7:0] exp, input string req, input bit want_susp);
    int n = 0;
    while (!ins_req && n < 20) begin @(negedge clk); n++; end
    chk(ins_req == 1'b1 && ins_char == exp, req, {ins_req, ins_char}, {1'b1, exp});
    if (want_susp) chk(tx_suspend == 1'b1, "R10", tx_suspend, 1);
    ins_ack = 1;
    @(negedge clk);
    ins_ack = 0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    repeat (n) begin @(negedge clk); if (ins_req) seen = 1; end
    chk(!seen, req, seen, 0);
  endtask

  function automatic bit model_step(input bit halted, input logic [1:0] rm, input bit any,
                                    input logic [7:0] prev, input logic [7:0] c);
    bit off, on;
    off = (rm == 1 && c == XOFF1) || (rm == 2 && c == XOFF2) || (rm == 3 && prev == XOFF1 && c == XOFF2);
    on  = (rm == 1 && c == XON1)  || (rm == 2 && c == XON2)  || (rm == 3 && prev == XON1 && c == XON2);
    if (off) return 1;
    if (on || any) return 0;
    return halted;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    cyc(3);
    chk(tx_suspend == 0 && ins_req == 0 && xoff_irq == 0, "R1", {tx_suspend, ins_req, xoff_irq}, 0);
    rst_n = 1;
    cyc(2);
    chk(tx_suspend == 0 && ins_req == 0 && xoff_irq == 0, "R1", {tx_suspend, ins_req, xoff_irq}, 0);

    mode = 4'b0001; irq_en = 1; tx_busy = 1;
    send(XOFF1);
    chk(tx_suspend == 0, "R3", tx_suspend, 0);
    chk(xoff_irq == 1, "R6", xoff_irq, 1);
    tx_busy = 0; cyc(2);
    chk(tx_suspend == 1, "R2", tx_suspend, 1);
    irq_ack = 1; cyc(1); irq_ack = 0; cyc(1);
    chk(xoff_irq == 0, "R6", xoff_irq, 0);
    send(XON1);
    chk(tx_suspend == 0, "R4", tx_suspend, 0);

    irq_en = 0;
    send(XOFF1);
    chk(tx_suspend == 1 && xoff_irq == 0, "R6", {tx_suspend, xoff_irq}, 2'b10);
    send(8'h45);
    chk(tx_suspend == 1, "R4", tx_suspend, 1);
    resume_any = 1;
    send(8'h46);
    chk(tx_suspend == 0, "R4", tx_suspend, 0);
    resume_any = 0;

    mode = 4'b0010;
    send(XOFF1);
    chk(tx_suspend == 0, "R11", tx_suspend, 0);
    send(XOFF2);
    chk(tx_suspend == 1, "R2", tx_suspend, 1);
    mode = 4'b0000; cyc(3);
    chk(tx_suspend == 0, "R11", tx_suspend, 0);

    mode = 4'b0011;
    send(XOFF1); send(8'h41); send(XOFF2);
    chk(tx_suspend == 0, "R5", tx_suspend, 0);
    send(XOFF1); send(XOFF2);
    chk(tx_suspend == 1, "R5", tx_suspend, 1);
    send(XON1); send(8'h42); send(XON2);
    chk(tx_suspend == 1, "R5", tx_suspend, 1);
    send(XON1); send(XON2);
    chk(tx_suspend == 0, "R5", tx_suspend, 0);

    begin
      bit halted = 0;
      for (int rm = 1; rm <= 3; rm++) begin
        logic [7:0] prev = 8'h00;
        mode = rm[3:0];
        for (int i = 0; i < 120; i++) begin
          logic [7:0] c;
          int k = $urandom_range(0, 5);
          bit any = ($urandom_range(0, 7) == 0);
          case (k)
            0: c = XON1; 1: c = XON2; 2: c = XOFF1; 3: c = XOFF2;
            default: c = 8'h40 + 8'($urandom_range(0, 31));
          endcase
          resume_any = any;
          halted = model_step(halted, rm[1:0], any, prev, c);
          prev = c;
          send(c);
          chk(tx_suspend == halted, rm == 3 ? "R5" : "R2", tx_suspend, halted);
        end
      end
      resume_any = 0;
    end

    rx_level = 7'd10;
    mode = 4'b1101;
    send(XOFF1);
    chk(tx_suspend == 1, "R2", tx_suspend, 1);
    quiet(4, "R9");
    rx_level = 7'd50;
    take(XOFF1, "R8", 1);
    take(XOFF2, "R8", 1);
    rx_level = 7'd30;
    quiet(6, "R9");
    rx_level = 7'd16;
    take(XON1, "R9", 1);
    take(XON2, "R9", 1);
    quiet(6, "R9");

    mode = 4'b1000;
    rx_level = 7'd60;
    take(XOFF2, "R8", 0);
    quiet(4, "R8");
    rx_level = 7'd0;
    take(XON2, "R9", 0);

    mode = 4'b0000;
    rx_level = 7'd60;
    quiet(6, "R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule